// File: doc/BRIEF.md
# Block-Copy DMA Channel with Peripheral Pacing

This block is a single DMA channel that moves a run of bytes from a source address to a destination address over a simple memory port. Software sets it up through a small register window. Two buffer slots each hold a source base, a destination base and a byte count. One control word selects everything else: the transfer kind (plain memory copy, transmit to a peripheral or receive from one), the beat width, whether each side's address is held fixed, which peripheral request line paces the beats, whether pacing is used at all, and a wait-state count.

A plain memory copy starts only when software writes the control word with both the enable bit and the start bit set. A peripheral transfer starts when the enable bit goes from 0 to 1. Software therefore loads the slot registers first and enables the channel last.

The engine drains slot 0 and then slot 1. Each beat reads at the source address and writes the same data at the destination address in the same cycle. When both counts reach zero the channel raises a sticky done flag and stops. An interrupt line reflects that flag when the done-interrupt enable bit is set.

Top module: `m2m_dma_chan`

## Requirements
- R1: After reset every register in the window reads zero, `busy_o` is low and `irq_o` is low.
- R2: Register offsets are control 0x00, interrupt 0x04, count slot0 0x10, count slot1 0x14, source slot0 0x18, source slot1 0x1C, destination slot0 0x2C, destination slot1 0x30. Each one reads back the value written, except that control bit 4 (start) always reads 0.
- R3: Control fields are: bit 3 enable; bit 4 start; bits 14:13 transfer kind (0 copy, 1 transmit, 2 receive, 3 never starts); bits 10:9 beat width (0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes). In copy kind, a control write with enable set and start clear does not start the channel. A write with both bits set starts it, and each destination byte then receives the corresponding source byte.
- R4: Each beat moves min(width, remaining count) bytes. The count drops by that amount. Each non-held address advances by the same amount, so at completion the count is 0 and a non-held base has grown by the original count.
- R5: Control bit 11 keeps the destination address fixed for every beat, and bit 12 keeps the source address fixed. A held address register is unchanged at completion.
- R6: Slot 0 is drained before slot 1, and a slot whose count is zero is skipped.
- R7: Interrupt register bit 1 is set when the transfer completes. A write to offset 0x04 with bit 1 at 0 clears it, and a write with bit 1 at 1 leaves it unchanged. `irq_o` equals that flag ANDed with control bit 2.
- R8: In transmit or receive kind, control bit 24 is 0 and bits 23:22 choose a request line (1 selects `periph_req_i[0]`, 2 selects `[1]`, 3 selects `[2]`, 0 selects none). A beat happens only while the selected line is high. The start itself is a 0 to 1 change of the enable bit.
- R9: With control bit 24 at 1, a transmit or receive transfer proceeds without looking at `periph_req_i`.
- R10: Control bits 31:25 give a wait count w. In transmit or receive kind each beat is followed by w idle cycles; copy kind ignores w. Without stalls `busy_o` stays high for beats*(1+w)+2 cycles, with w taken as 0 in copy kind.
- R11: Clearing the enable bit during a transfer stops it within two cycles. The done flag is not set, and the counts freeze.
- R12: `mem_rd_o` and `mem_wr_o` are asserted together and only while busy. A beat carries 1 to 4 bytes in `mem_wr_bytes_o`, on the low byte lanes of `mem_wr_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| periph_req_i | input | 3 | Peripheral request lines |
| mem_rd_o | output | 1 | Beat read strobe |
| mem_rd_addr_o | output | AW | Beat source byte address |
| mem_rd_data_i | input | 32 | Read data, byte at address on bits 7:0 |
| mem_wr_o | output | 1 | Beat write strobe |
| mem_wr_addr_o | output | AW | Beat destination byte address |
| mem_wr_data_o | output | 32 | Write data |
| mem_wr_bytes_o | output | 3 | Bytes written this beat |
| busy_o | output | 1 | Transfer in progress |
| irq_o | output | 1 | Done interrupt |

## Verification
Most internal faults in this channel surface quickly at the ports. A wrong step amount or a wrong slot index shows up as a corrupted destination byte or a wrong count readback as soon as the transfer ends. A broken wait counter changes how many cycles `busy_o` stays high, off by a multiple of the beat count. Pacing or abort faults are visible within a few cycles: the count readback moves while the request line is low, or keeps moving after enable is cleared. The bench mixes seeded random copies of varied width, length and alignment with directed runs through holds, pacing, abort and the done-flag clear.

// File: rtl/m2m_dma_pkg.sv
package m2m_dma_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [1:0] {
    XK_COPY = 2'd0,
    XK_TX   = 2'd1,
    XK_RX   = 2'd2,
    XK_RSVD = 2'd3
  } xfer_kind_e;

  typedef struct packed {
    logic [6:0] wait_cnt;
    logic       no_pace;
    logic [1:0] req_sel;
    logic [6:0] rsvd_hi;
    xfer_kind_e kind;
    logic       hold_src;
    logic       hold_dst;
    logic [1:0] width;
    logic [3:0] rsvd_mid;
    logic       start;
    logic       en;
    logic       done_ie;
    logic [1:0] rsvd_lo;
  } ctrl_t;

  localparam logic [5:0] OFS_CTRL = 6'h00;
  localparam logic [5:0] OFS_IRQ  = 6'h04;
  localparam logic [5:0] OFS_CNT0 = 6'h10;
  localparam logic [5:0] OFS_CNT1 = 6'h14;
  localparam logic [5:0] OFS_SRC0 = 6'h18;
  localparam logic [5:0] OFS_SRC1 = 6'h1C;
  localparam logic [5:0] OFS_DST0 = 6'h2C;
  localparam logic [5:0] OFS_DST1 = 6'h30;

  function automatic logic [2:0] width_bytes(logic [1:0] w);
    case (w)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/m2m_dma_slot.sv
module m2m_dma_slot #(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_cnt_i,
  input  logic             wr_src_i,
  input  logic             wr_dst_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic [AW-1:0]    addr_wdata_i,
  input  logic             adv_i,
  input  logic [2:0]       step_i,
  input  logic             hold_src_i,
  input  logic             hold_dst_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [AW-1:0]    src_o,
  output logic [AW-1:0]    dst_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      src_o <= '0;
      dst_o <= '0;
    end else if (adv_i) begin
      cnt_o <= cnt_o - CNT_W'(step_i);
      if (!hold_src_i) src_o <= src_o + AW'(step_i);
      if (!hold_dst_i) dst_o <= dst_o + AW'(step_i);
    end else begin
      if (wr_cnt_i) cnt_o <= cnt_wdata_i;
      if (wr_src_i) src_o <= addr_wdata_i;
      if (wr_dst_i) dst_o <= addr_wdata_i;
    end
  end
endmodule

// File: rtl/m2m_dma_ctrl.sv
module m2m_dma_ctrl
  import m2m_dma_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [5:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          busy_i,
  input  logic          done_set_i,
  output ctrl_t         cfg_o,
  output logic          start_o,
  output logic          done_o,
  output logic          irq_o
);
  ctrl_t wr_cfg;
  logic  wr_ctrl, wr_irq, kick;

  assign wr_cfg  = ctrl_t'(wdata_i);
  assign wr_ctrl = we_i && (addr_i == OFS_CTRL);
  assign wr_irq  = we_i && (addr_i == OFS_IRQ);

  // copy kind needs the start bit; peripheral kinds start on enable rising
  always_comb begin
    kick = 1'b0;
    if (wr_ctrl && wr_cfg.en && !busy_i) begin
      case (wr_cfg.kind)
        XK_COPY:      kick = wr_cfg.start;
        XK_TX, XK_RX: kick = !cfg_o.en;
        default:      kick = 1'b0;
      endcase
    end
  end
  assign start_o = kick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= '0;
      done_o <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        cfg_o       <= wr_cfg;
        cfg_o.start <= 1'b0;
      end
      if (done_set_i)                done_o <= 1'b1;
      else if (wr_irq && !wdata_i[1]) done_o <= 1'b0;
    end
  end

  assign irq_o = done_o && cfg_o.done_ie;
endmodule

// File: rtl/m2m_dma_engine.sv
module m2m_dma_engine
  import m2m_dma_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  en_i,
  input  xfer_kind_e            kind_i,
  input  logic [1:0]            width_i,
  input  logic [1:0]            req_sel_i,
  input  logic                  no_pace_i,
  input  logic [6:0]            wait_i,
  input  logic [2:0]            periph_req_i,
  input  logic [1:0][CNT_W-1:0] cnt_i,
  input  logic [1:0][AW-1:0]    src_i,
  input  logic [1:0][AW-1:0]    dst_i,
  input  logic [DW-1:0]         rd_data_i,
  output logic [1:0]            adv_o,
  output logic [2:0]            step_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  mem_rd_o,
  output logic [AW-1:0]         mem_rd_addr_o,
  output logic                  mem_wr_o,
  output logic [AW-1:0]         mem_wr_addr_o,
  output logic [DW-1:0]         mem_wr_data_o,
  output logic [2:0]            mem_wr_bytes_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAIT} st_e;

  st_e        st_q;
  logic       cur_q;
  logic [6:0] wcnt_q;

  logic [CNT_W-1:0] cnt_cur;
  logic [2:0]       wb;
  logic             periph, req_ok, pace_ok, empty, beat;

  assign cnt_cur = cnt_i[cur_q];
  assign wb      = width_bytes(width_i);
  assign periph  = (kind_i == XK_TX) || (kind_i == XK_RX);
  assign empty   = (cnt_cur == '0);

  always_comb begin
    case (req_sel_i)
      2'd1:    req_ok = periph_req_i[0];
      2'd2:    req_ok = periph_req_i[1];
      2'd3:    req_ok = periph_req_i[2];
      default: req_ok = 1'b0;
    endcase
  end

  assign pace_ok = !periph || no_pace_i || req_ok;
  assign beat    = (st_q == ST_RUN) && en_i && !empty && pace_ok;
  assign step_o  = (cnt_cur < CNT_W'(wb)) ? cnt_cur[2:0] : wb;
  assign done_o  = (st_q == ST_RUN) && en_i && empty && cur_q;

  always_comb begin
    adv_o        = '0;
    adv_o[cur_q] = beat;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cur_q  <= 1'b0;
      wcnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_RUN;
          cur_q <= 1'b0;
        end
        ST_RUN: begin
          if (!en_i) st_q <= ST_IDLE;
          else if (empty) begin
            if (!cur_q) cur_q <= 1'b1;
            else        st_q  <= ST_IDLE;
          end else if (beat && periph && (wait_i != '0)) begin
            st_q   <= ST_WAIT;
            wcnt_q <= wait_i;
          end
        end
        ST_WAIT: begin
          if (!en_i)              st_q   <= ST_IDLE;
          else if (wcnt_q == 7'd1) st_q   <= ST_RUN;
          else                    wcnt_q <= wcnt_q - 7'd1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o         = (st_q != ST_IDLE);
  assign mem_rd_o       = beat;
  assign mem_wr_o       = beat;
  assign mem_rd_addr_o  = src_i[cur_q];
  assign mem_wr_addr_o  = dst_i[cur_q];
  assign mem_wr_data_o  = rd_data_i;
  assign mem_wr_bytes_o = beat ? step_o : 3'd0;
endmodule

// File: rtl/m2m_dma_chan.sv
module m2m_dma_chan
  import m2m_dma_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [5:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic [2:0]    periph_req_i,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_rd_addr_o,
  input  logic [31:0]   mem_rd_data_i,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_wr_addr_o,
  output logic [31:0]   mem_wr_data_o,
  output logic [2:0]    mem_wr_bytes_o,
  output logic          busy_o,
  output logic          irq_o
);
  localparam int unsigned NSLOT = 2;

  ctrl_t                     cfg;
  logic                      start, done_flag, done_set;
  logic [NSLOT-1:0]          adv;
  logic [2:0]                step;
  logic [NSLOT-1:0][CNT_W-1:0] cnt;
  logic [NSLOT-1:0][AW-1:0]    src, dst;

  m2m_dma_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .busy_i     (busy_o),
    .done_set_i (done_set),
    .cfg_o      (cfg),
    .start_o    (start),
    .done_o     (done_flag),
    .irq_o      (irq_o)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [5:0] OC = (s == 0) ? OFS_CNT0 : OFS_CNT1;
    localparam logic [5:0] OS = (s == 0) ? OFS_SRC0 : OFS_SRC1;
    localparam logic [5:0] OD = (s == 0) ? OFS_DST0 : OFS_DST1;
    m2m_dma_slot #(.AW(AW), .CNT_W(CNT_W)) u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_cnt_i     (reg_we_i && reg_addr_i == OC),
      .wr_src_i     (reg_we_i && reg_addr_i == OS),
      .wr_dst_i     (reg_we_i && reg_addr_i == OD),
      .cnt_wdata_i  (reg_wdata_i[CNT_W-1:0]),
      .addr_wdata_i (reg_wdata_i[AW-1:0]),
      .adv_i        (adv[s]),
      .step_i       (step),
      .hold_src_i   (cfg.hold_src),
      .hold_dst_i   (cfg.hold_dst),
      .cnt_o        (cnt[s]),
      .src_o        (src[s]),
      .dst_o        (dst[s])
    );
  end

  m2m_dma_engine #(.AW(AW), .CNT_W(CNT_W)) u_eng (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start),
    .en_i           (cfg.en),
    .kind_i         (cfg.kind),
    .width_i        (cfg.width),
    .req_sel_i      (cfg.req_sel),
    .no_pace_i      (cfg.no_pace),
    .wait_i         (cfg.wait_cnt),
    .periph_req_i   (periph_req_i),
    .cnt_i          (cnt),
    .src_i          (src),
    .dst_i          (dst),
    .rd_data_i      (mem_rd_data_i),
    .adv_o          (adv),
    .step_o         (step),
    .busy_o         (busy_o),
    .done_o         (done_set),
    .mem_rd_o       (mem_rd_o),
    .mem_rd_addr_o  (mem_rd_addr_o),
    .mem_wr_o       (mem_wr_o),
    .mem_wr_addr_o  (mem_wr_addr_o),
    .mem_wr_data_o  (mem_wr_data_o),
    .mem_wr_bytes_o (mem_wr_bytes_o)
  );

  always_comb begin
    case (reg_addr_i)
      OFS_CTRL: reg_rdata_o = cfg;
      OFS_IRQ:  reg_rdata_o = {30'd0, done_flag, 1'b0};
      OFS_CNT0: reg_rdata_o = 32'(cnt[0]);
      OFS_CNT1: reg_rdata_o = 32'(cnt[1]);
      OFS_SRC0: reg_rdata_o = 32'(src[0]);
      OFS_SRC1: reg_rdata_o = 32'(src[1]);
      OFS_DST0: reg_rdata_o = 32'(dst[0]);
      OFS_DST1: reg_rdata_o = 32'(dst[1]);
      default:  reg_rdata_o = 32'd0;
    endcase
  end
endmodule

// File: rtl/m2m_dma_chan_chk.sv
module m2m_dma_chan_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          irq_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic [2:0]    mem_wr_bytes_o,
  input logic [AW-1:0] mem_rd_addr_o,
  input logic [AW-1:0] mem_wr_addr_o,
  input logic          done_flag,
  input logic          hold_src,
  input logic          hold_dst,
  input logic          periph_wait,
  input logic          cfg_en
);
  AST_RD_WR_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o == mem_wr_o); // R12
  AST_BEAT_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (mem_wr_bytes_o != 3'd0 && mem_wr_bytes_o <= 3'd4)); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_wr_o); // R12
  AST_IRQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_flag); // R7
  AST_SRC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && hold_src && $past(mem_rd_o) && $past(hold_src))
      |-> mem_rd_addr_o == $past(mem_rd_addr_o)); // R5
  AST_DST_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && hold_dst && $past(mem_wr_o) && $past(hold_dst))
      |-> mem_wr_addr_o == $past(mem_wr_addr_o)); // R5
  AST_WAIT_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && periph_wait) |=> !mem_wr_o); // R10
  AST_ABORT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !cfg_en) |=> !busy_o); // R11
endmodule

bind m2m_dma_chan m2m_dma_chan_chk #(.AW(AW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .busy_o         (busy_o),
  .irq_o          (irq_o),
  .mem_rd_o       (mem_rd_o),
  .mem_wr_o       (mem_wr_o),
  .mem_wr_bytes_o (mem_wr_bytes_o),
  .mem_rd_addr_o  (mem_rd_addr_o),
  .mem_wr_addr_o  (mem_wr_addr_o),
  .done_flag      (done_flag),
  .hold_src       (cfg.hold_src),
  .hold_dst       (cfg.hold_dst),
  .periph_wait    ((cfg.kind == m2m_dma_pkg::XK_TX || cfg.kind == m2m_dma_pkg::XK_RX)
                   && cfg.wait_cnt != 7'd0),
  .cfg_en         (cfg.en)
);

// File: tb/m2m_dma_chan_tb.sv
`timescale 1ns/1ps
module m2m_dma_chan_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [5:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [2:0]  periph_req_i = '0;
  logic        mem_rd_o, mem_wr_o, busy_o, irq_o;
  logic [31:0] mem_rd_addr_o, mem_wr_addr_o, mem_wr_data_o;
  logic [31:0] mem_rd_data_i;
  logic [2:0]  mem_wr_bytes_o;

  logic [7:0] mem [256];
  logic [7:0] expv [256];
  int checks = 0;
  int fails = 0;

  always #2 clk_i = ~clk_i;

  m2m_dma_chan u_dut (.*);

  always_comb
    for (int b = 0; b < 4; b++)
      mem_rd_data_i[8*b +: 8] = mem[8'(mem_rd_addr_o[7:0] + 8'(b))];

  always @(posedge clk_i)
    if (mem_wr_o)
      for (int b = 0; b < 4; b++)
        if (b < int'(mem_wr_bytes_o))
          mem[8'(mem_wr_addr_o[7:0] + 8'(b))] <= mem_wr_data_o[8*b +: 8];

  localparam logic [31:0] EN = 32'h8, GO = 32'h10, IE = 32'h4;
  localparam logic [31:0] HDST = 32'h800, HSRC = 32'h1000, NOPACE = 32'h0100_0000;
  function automatic logic [31:0] kind_f(int k); return 32'(k) << 13; endfunction
  function automatic logic [31:0] pw_f(int p);   return 32'(p) << 9;  endfunction
  function automatic logic [31:0] rs_f(int r);   return 32'(r) << 22; endfunction
  function automatic logic [31:0] ws_f(int w);   return 32'(w) << 25; endfunction
  function automatic int wbytes(int p); return (p == 0) ? 1 : (p == 1) ? 2 : 4; endfunction
  function automatic int nbeats(int len, int p); return (len + wbytes(p) - 1) / wbytes(p); endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #0.5;
    d = reg_rdata_o;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o && n < 5000) begin n++; @(negedge clk_i); end
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    for (int i = 0; i < 256; i++) expv[i] = mem[i];
  endtask

  task automatic reset_regs();
    wr(6'h00, 32'h0);
    wr(6'h04, 32'h0);
    wr(6'h10, 32'h0);
    wr(6'h14, 32'h0);
  endtask

  task automatic cmp_mem(input string req);
    int bad = -1;
    for (int i = 0; i < 256; i++) if (bad < 0 && mem[i] !== expv[i]) bad = i;
    if (bad < 0) chk(1'b1, req, "mem", 0, 0);
    else chk(1'b0, req, $sformatf("mem[%0h]", bad), mem[bad], expv[bad]);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    void'($urandom(32'h0d3a5eed));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(6'h00, d); chk(d == 0, "R1", "ctrl", d, 0);
    rd(6'h10, d); chk(d == 0, "R1", "cnt0", d, 0);
    rd(6'h30, d); chk(d == 0, "R1", "dst1", d, 0);
    chk(!busy_o && !irq_o, "R1", "busy/irq", {busy_o, irq_o}, 0);

    // R2 readback; control write with start but enable clear
    wr(6'h10, 32'h1234); wr(6'h14, 32'h0BCD);
    wr(6'h18, 32'hA0A0_0001); wr(6'h1C, 32'h1234_5678);
    wr(6'h2C, 32'hDEAD_BEEF); wr(6'h30, 32'h0000_00F0);
    rd(6'h10, d); chk(d == 32'h1234, "R2", "cnt0", d, 32'h1234);
    rd(6'h14, d); chk(d == 32'h0BCD, "R2", "cnt1", d, 32'h0BCD);
    rd(6'h18, d); chk(d == 32'hA0A0_0001, "R2", "src0", d, 32'hA0A0_0001);
    rd(6'h1C, d); chk(d == 32'h1234_5678, "R2", "src1", d, 32'h1234_5678);
    rd(6'h2C, d); chk(d == 32'hDEAD_BEEF, "R2", "dst0", d, 32'hDEAD_BEEF);
    rd(6'h30, d); chk(d == 32'hF0, "R2", "dst1", d, 32'hF0);
    wr(6'h00, GO | IE | pw_f(2) | HSRC);
    rd(6'h00, d); chk(d == (IE | pw_f(2) | HSRC), "R2", "ctrl start reads 0", d, IE | pw_f(2) | HSRC);
    reset_regs();

    // R3 enable without start does not launch a copy
    wr(6'h10, 32'd4); wr(6'h18, 32'h0); wr(6'h2C, 32'h80);
    wr(6'h00, EN);
    repeat (3) @(negedge clk_i);
    rd(6'h10, d);
    chk(!busy_o && d == 4, "R3", "no start without start bit", d, 4);
    reset_regs();

    // R3 R4 R10: random copies, wait field must be ignored in copy kind
    for (int it = 0; it < 8; it++) begin
      int p, len0, len1, s0, d0, s1, d1, w;
      p = $urandom_range(0, 2);
      len0 = (it == 0) ? 1 : $urandom_range(1, 20);
      len1 = (it < 2) ? 0 : $urandom_range(0, 10);
      s0 = $urandom_range(0, 63); d0 = $urandom_range(128, 170);
      s1 = $urandom_range(96, 120); d1 = $urandom_range(200, 230);
      w = $urandom_range(0, 9);
      fill_mem();
      for (int i = 0; i < len0; i++) expv[d0 + i] = expv[s0 + i];
      for (int i = 0; i < len1; i++) expv[d1 + i] = expv[s1 + i];
      wr(6'h10, 32'(len0)); wr(6'h18, 32'(s0)); wr(6'h2C, 32'(d0));
      wr(6'h14, 32'(len1)); wr(6'h1C, 32'(s1)); wr(6'h30, 32'(d1));
      wr(6'h00, EN | GO | pw_f(p) | ws_f(w));
      wait_idle(n);
      cmp_mem("R3");
      chk(n == nbeats(len0, p) + nbeats(len1, p) + 2, "R10", "copy busy cycles",
          n, nbeats(len0, p) + nbeats(len1, p) + 2);
      rd(6'h10, d); chk(d == 0, "R4", "cnt0 end", d, 0);
      rd(6'h18, d); chk(d == 32'(s0 + len0), "R4", "src0 end", d, s0 + len0);
      rd(6'h30, d); chk(d == 32'(d1 + len1), "R4", "dst1 end", d, d1 + len1);
      wr(6'h04, 32'h0);
    end
    reset_regs();

    // R6 empty slot0 skipped; R7 done set but irq masked
    fill_mem();
    for (int i = 0; i < 5; i++) expv[8'hC0 + i] = expv[8'h30 + i];
    wr(6'h14, 32'd5); wr(6'h1C, 32'h30); wr(6'h30, 32'hC0);
    wr(6'h00, EN | GO | pw_f(1));
    wait_idle(n);
    cmp_mem("R6");
    chk(n == 3 + 2, "R6", "busy cycles slot0 skip", n, 5);
    rd(6'h04, d); chk(d == 32'h2 && !irq_o, "R7", "done set irq masked", {d, irq_o}, 64'h2_0);

    // R7 irq with enable, write-one keeps, write-zero clears
    wr(6'h04, 32'h0);
    fill_mem();
    for (int i = 0; i < 4; i++) expv[8'hC0 + i] = expv[8'h30 + i];
    wr(6'h14, 32'd4); wr(6'h1C, 32'h30); wr(6'h30, 32'hC0);
    wr(6'h00, EN | GO | IE | pw_f(2));
    wait_idle(n);
    chk(irq_o == 1'b1, "R7", "irq raised", irq_o, 1);
    wr(6'h04, 32'h2);
    rd(6'h04, d); chk(d == 32'h2 && irq_o, "R7", "write bit1=1 keeps", d, 2);
    wr(6'h04, 32'h0);
    rd(6'h04, d); chk(d == 0 && !irq_o, "R7", "write zero clears", {d, irq_o}, 0);
    reset_regs();

    // R5 R9 hold destination, transmit without pacing, 4-byte beats
    fill_mem();
    for (int i = 0; i < 4; i++) expv[8'hF0 + i] = expv[8'h14 + i];
    wr(6'h10, 32'd8); wr(6'h18, 32'h10); wr(6'h2C, 32'hF0);
    wr(6'h00, EN | kind_f(1) | HDST | pw_f(2) | NOPACE | rs_f(1));
    wait_idle(n);
    cmp_mem("R5");
    rd(6'h2C, d); chk(d == 32'hF0, "R5", "held dst", d, 32'hF0);
    rd(6'h18, d); chk(d == 32'h18, "R4", "src advanced", d, 32'h18);
    rd(6'h04, d); chk(d == 32'h2, "R9", "done without request", d, 2);
    reset_regs();

    // R5 R10 hold source, receive with 2 wait states, 1-byte beats
    fill_mem();
    for (int i = 0; i < 3; i++) expv[8'h80 + i] = expv[8'h40];
    wr(6'h10, 32'd3); wr(6'h18, 32'h40); wr(6'h2C, 32'h80);
    wr(6'h00, EN | kind_f(2) | HSRC | pw_f(0) | NOPACE | ws_f(2));
    wait_idle(n);
    cmp_mem("R5");
    chk(n == 3 * 3 + 2, "R10", "wait-state busy cycles", n, 11);
    rd(6'h18, d); chk(d == 32'h40, "R5", "held src", d, 32'h40);
    reset_regs();

    // R8 pacing by selected request line
    fill_mem();
    for (int i = 0; i < 4; i++) expv[8'hA0 + i] = expv[8'h20 + i];
    wr(6'h10, 32'd4); wr(6'h18, 32'h20); wr(6'h2C, 32'hA0);
    wr(6'h00, EN | kind_f(1) | pw_f(1) | rs_f(2));
    repeat (5) @(negedge clk_i);
    rd(6'h10, d); chk(busy_o && d == 4, "R8", "stalled without request", d, 4);
    periph_req_i = 3'b001;
    repeat (5) @(negedge clk_i);
    rd(6'h10, d); chk(busy_o && d == 4, "R8", "other line ignored", d, 4);
    periph_req_i = 3'b010;
    wait_idle(n);
    periph_req_i = 3'b000;
    rd(6'h10, d); chk(d == 0 && !busy_o, "R8", "runs with selected line", d, 0);
    cmp_mem("R8");
    reset_regs();

    // R11 abort by clearing enable
    fill_mem();
    wr(6'h10, 32'd40); wr(6'h18, 32'h0); wr(6'h2C, 32'h80);
    wr(6'h00, EN | GO | pw_f(0));
    wr(6'h00, 32'h0);
    repeat (2) @(negedge clk_i);
    begin
      logic [31:0] c1, c2;
      rd(6'h10, c1);
      chk(!busy_o && c1 > 0 && c1 < 40, "R11", "stopped mid-run", c1, 39);
      repeat (5) @(negedge clk_i);
      rd(6'h10, c2); chk(c2 == c1, "R11", "count frozen", c2, c1);
      rd(6'h04, d);  chk(d == 0, "R11", "no done on abort", d, 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule